// File: doc/BRIEF.md
# Out-of-Order Instruction Issue Queue

This block holds renamed instructions between dispatch and the execution units. Each instruction carries a sequence number, a functional class, two source physical registers and optionally one destination register. A per-register ready scoreboard decides whether a source is already available when the instruction enters. Results broadcast by execute wake any waiting entry that reads that register. Each cycle the queue picks ready instructions, oldest first, and puts them on a small set of issue slots.

Selection is done separately for five classes. Each class has its own per-cycle limit, and an overall cap applies across all classes. An instruction marked non-speculative is held until commit names its exact sequence number. A squash drops every entry younger than a given sequence number. Dispatch must respect the full flag and the free-entry count. Sequence numbers are compared as plain unsigned values, so the producer keeps them increasing and free of wrap.

Top module: `iq_top`

## Requirements
- R1: After synchronous active-low reset the queue is empty: free count 16, full low, no issue slot valid, and every one of the 64 register ready bits is set.
- R2: The free count equals 16 minus the number of held entries, and full is high exactly when it is zero. A dispatch presented while full is dropped and never issues.
- R3: A dispatch with a destination clears that register's ready bit at the clock edge. A later instruction that reads the register waits until it is broadcast.
- R4: A broadcast sets the register's ready bit and marks the matching operands of every held entry as ready. Such an entry can issue in the next cycle.
- R5: A broadcast in the same cycle as a dispatch that reads the same register makes that operand ready at entry.
- R6: Within one class, eligible entries issue in increasing sequence-number order. An older entry that is not ready does not block a younger ready one.
- R7: Class codes are integer 0, floating-point 1, branch 2, memory 3 and miscellaneous 4. The integer class issues at most 2 per cycle and every other class at most 1.
- R8: At most 3 instructions issue per cycle. Classes are granted in the order integer, floating-point, branch, memory, miscellaneous. Issue slots fill from slot 0 with no gaps, and within a class the oldest entry takes the lower slot.
- R9: A non-speculative entry never issues until commit presents its exact sequence number. Once released and ready, it issues in the next cycle. A commit carrying any other number has no effect.
- R10: A squash invalidates every entry whose sequence number is greater than the squash number, including held non-speculative entries. Those entries do not issue even in the squash cycle, and a dispatch in the squash cycle is dropped.
- R11: An entry is shown on the issue slots in the same cycle it is eligible, is removed at that clock edge, and issues exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_seq | input | 8 | Sequence number of the dispatched instruction |
| disp_cls | input | 3 | Functional class code |
| disp_src0 | input | 6 | First source physical register |
| disp_src1 | input | 6 | Second source physical register |
| disp_has_dst | input | 1 | Instruction writes a destination register |
| disp_dst | input | 6 | Destination physical register |
| disp_nonspec | input | 1 | Hold until released by commit |
| wake_valid | input | 1 | Result broadcast this cycle |
| wake_reg | input | 6 | Register whose result is broadcast |
| commit_valid | input | 1 | Commit release this cycle |
| commit_seq | input | 8 | Sequence number released by commit |
| squash_valid | input | 1 | Squash this cycle |
| squash_seq | input | 8 | Entries younger than this number are dropped |
| free_cnt | output | 5 | Number of free entries |
| full | output | 1 | No free entry |
| iss_valid | output | 3 | Issue slot valid bits |
| iss_seq | output | 24 | Sequence number per slot, slot s at bits 8s+7..8s |
| iss_cls | output | 9 | Class per slot, slot s at bits 3s+2..3s |

## Verification
The bench goes after the cases where priority or timing is easy to get wrong. A producer and its consumer wake on the same edge; a design without the bypass would strand the consumer forever. Five classes become ready at once under the total cap; a wrong grant order or a missing cap shows up as an extra or misplaced slot. An older entry waits while a younger one is ready, and a design that selects by position instead of age issues them in the wrong order. A squash lands on a cycle in which a younger entry is already ready, and a late squash would let it escape. A commit with the wrong number must not release a held entry, and a dispatch at full occupancy must vanish instead of overwriting a slot.

// File: rtl/iq_pkg.sv
`timescale 1ns/1ps
// Shared constants, class codes and entry layout for the issue queue.
// Assumes sequence numbers never wrap while in flight.
package iq_pkg;
    localparam int N_ENT  = 16;
    localparam int N_PREG = 64;
    localparam int SEQ_W  = 8;
    localparam int N_CLS  = 5;
    localparam int ISS_W  = 3;
    localparam int CW_MAX = 2;
    localparam int PREG_W = $clog2(N_PREG);
    localparam int IDX_W  = $clog2(N_ENT);
    localparam int CNT_W  = $clog2(N_ENT + 1);
    localparam int CLS_W  = 3;

    typedef enum logic [CLS_W-1:0] {
        C_INT  = 3'd0,
        C_FP   = 3'd1,
        C_BR   = 3'd2,
        C_MEM  = 3'd3,
        C_MISC = 3'd4
    } iq_cls_e;

    // Per-class issue limit per cycle.
    function automatic int cls_width(input int c);
        return (c == 0) ? 2 : 1;
    endfunction

    typedef struct packed {
        logic              vld;
        logic [SEQ_W-1:0]  seq;
        logic [CLS_W-1:0]  cls;
        logic [PREG_W-1:0] s0;
        logic [PREG_W-1:0] s1;
        logic              r0;
        logic              r1;
        logic              nonspec;
        logic              rel;
    } iq_ent_t;
endpackage

// File: rtl/iq_scoreboard.sv
`timescale 1ns/1ps
// Register-ready scoreboard. One bit per physical register: set on a
// result broadcast, cleared when a new producer enters the queue (the
// clear wins if both hit the same register). Lookups see a broadcast of
// the same cycle through a bypass.
module iq_scoreboard #(
    parameter int NREG = 64,
    parameter int RW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wk_vld,
    input  logic [RW-1:0] wk_reg,
    input  logic          clr_vld,
    input  logic [RW-1:0] clr_reg,
    input  logic [RW-1:0] q0,
    input  logic [RW-1:0] q1,
    output logic          rdy0,
    output logic          rdy1
);
    logic [NREG-1:0] rdy;

    // Ready-bit update: broadcast sets, producer allocation clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy <= '1;
        end else begin
            if (wk_vld)  rdy[wk_reg]  <= 1'b1;
            if (clr_vld) rdy[clr_reg] <= 1'b0;
        end
    end

    // Source lookup with same-cycle broadcast bypass.
    always_comb begin
        rdy0 = rdy[q0] | (wk_vld && (wk_reg == q0));
        rdy1 = rdy[q1] | (wk_vld && (wk_reg == q1));
    end
endmodule

// File: rtl/iq_pick.sv
`timescale 1ns/1ps
// Oldest-first picker for one class. Returns up to WIDTH eligible
// entries, smallest sequence number in lane 0. Lanes at or above WIDTH
// stay idle. Assumes sequence numbers are unique.
module iq_pick #(
    parameter int N     = 16,
    parameter int SW    = 8,
    parameter int WIDTH = 1,
    parameter int LANES = 2,
    parameter int IW    = $clog2(N)
) (
    input  logic [N-1:0]                elig,
    input  logic [N-1:0][SW-1:0]        seqs,
    output logic [LANES-1:0]            pv,
    output logic [LANES-1:0][IW-1:0]    pidx
);
    logic [N-1:0]  taken;
    logic          found;
    logic [IW-1:0] bi;
    logic [SW-1:0] bs;

    // Repeated minimum search, excluding entries already chosen.
    always_comb begin
        taken = '0;
        pv    = '0;
        pidx  = '0;
        found = 1'b0;
        bi    = '0;
        bs    = '0;
        for (int k = 0; k < LANES; k++) begin
            found = 1'b0;
            bi    = '0;
            bs    = '0;
            if (k < WIDTH) begin
                for (int i = 0; i < N; i++) begin
                    if (elig[i] && !taken[i] && (!found || seqs[i] < bs)) begin
                        found = 1'b1;
                        bi    = IW'(i);
                        bs    = seqs[i];
                    end
                end
            end
            pv[k]   = found;
            pidx[k] = bi;
            if (found) taken[bi] = 1'b1;
        end
    end
endmodule

// File: rtl/iq_merge.sv
`timescale 1ns/1ps
// Merges per-class picks onto the issue slots under the total cap.
// Classes are granted in index order, lanes in age order; slots fill
// from 0 without gaps. Also returns a mask of entries that leave.
module iq_merge #(
    parameter int N     = 16,
    parameter int NC    = 5,
    parameter int LANES = 2,
    parameter int SLOTS = 3,
    parameter int IW    = $clog2(N)
) (
    input  logic [NC-1:0][LANES-1:0]          pv,
    input  logic [NC-1:0][LANES-1:0][IW-1:0]  pidx,
    output logic [SLOTS-1:0]                  sv,
    output logic [SLOTS-1:0][IW-1:0]          sidx,
    output logic [N-1:0]                      gone
);
    // Walk classes in priority order and hand out slots until full.
    always_comb begin
        int slot;
        slot = 0;
        sv   = '0;
        sidx = '0;
        gone = '0;
        for (int c = 0; c < NC; c++) begin
            for (int k = 0; k < LANES; k++) begin
                if (pv[c][k] && slot < SLOTS) begin
                    sv[slot]         = 1'b1;
                    sidx[slot]       = pidx[c][k];
                    gone[pidx[c][k]] = 1'b1;
                    slot             = slot + 1;
                end
            end
        end
    end
endmodule

// File: rtl/iq_top.sv
`timescale 1ns/1ps
// Issue queue top. Stores entries, tracks operand readiness via the
// scoreboard and broadcasts, holds non-speculative entries until commit
// releases them, drops younger entries on squash, and issues oldest
// ready entries per class under per-class and total limits.
// Assumes dispatch obeys full and sequence numbers increase without wrap.
module iq_top
    import iq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     disp_valid,
    input  logic [SEQ_W-1:0]         disp_seq,
    input  logic [CLS_W-1:0]         disp_cls,
    input  logic [PREG_W-1:0]        disp_src0,
    input  logic [PREG_W-1:0]        disp_src1,
    input  logic                     disp_has_dst,
    input  logic [PREG_W-1:0]        disp_dst,
    input  logic                     disp_nonspec,
    input  logic                     wake_valid,
    input  logic [PREG_W-1:0]        wake_reg,
    input  logic                     commit_valid,
    input  logic [SEQ_W-1:0]         commit_seq,
    input  logic                     squash_valid,
    input  logic [SEQ_W-1:0]         squash_seq,
    output logic [CNT_W-1:0]         free_cnt,
    output logic                     full,
    output logic [ISS_W-1:0]         iss_valid,
    output logic [ISS_W*SEQ_W-1:0]   iss_seq,
    output logic [ISS_W*CLS_W-1:0]   iss_cls
);
    iq_ent_t                           ent [N_ENT];
    logic [N_ENT-1:0]                  elig;
    logic [N_CLS-1:0][N_ENT-1:0]       elig_c;
    logic [N_ENT-1:0][SEQ_W-1:0]       seqv;
    logic [N_CLS-1:0][CW_MAX-1:0]      pv;
    logic [N_CLS-1:0][CW_MAX-1:0][IDX_W-1:0] pidx;
    logic [ISS_W-1:0]                  sv;
    logic [ISS_W-1:0][IDX_W-1:0]       sidx;
    logic [N_ENT-1:0]                  gone;
    logic [CNT_W-1:0]                  occ;
    logic [IDX_W-1:0]                  alloc_idx;
    logic                              disp_ok;
    logic                              sr0, sr1;

    assign disp_ok = disp_valid && !full && !squash_valid;

    iq_scoreboard #(.NREG(N_PREG), .RW(PREG_W)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .wk_vld  (wake_valid),
        .wk_reg  (wake_reg),
        .clr_vld (disp_ok && disp_has_dst),
        .clr_reg (disp_dst),
        .q0      (disp_src0),
        .q1      (disp_src1),
        .rdy0    (sr0),
        .rdy1    (sr1)
    );

    // Eligibility: valid, both operands ready, released if held, not squashed now.
    always_comb begin
        for (int i = 0; i < N_ENT; i++) begin
            seqv[i] = ent[i].seq;
            elig[i] = ent[i].vld && ent[i].r0 && ent[i].r1 &&
                      (!ent[i].nonspec || ent[i].rel) &&
                      !(squash_valid && (ent[i].seq > squash_seq));
            for (int c = 0; c < N_CLS; c++)
                elig_c[c][i] = elig[i] && (ent[i].cls == CLS_W'(c));
        end
    end

    for (genvar c = 0; c < N_CLS; c++) begin : g_cls
        iq_pick #(
            .N(N_ENT), .SW(SEQ_W), .WIDTH(cls_width(c)), .LANES(CW_MAX), .IW(IDX_W)
        ) u_pick (
            .elig (elig_c[c]),
            .seqs (seqv),
            .pv   (pv[c]),
            .pidx (pidx[c])
        );
    end

    iq_merge #(
        .N(N_ENT), .NC(N_CLS), .LANES(CW_MAX), .SLOTS(ISS_W), .IW(IDX_W)
    ) u_merge (
        .pv   (pv),
        .pidx (pidx),
        .sv   (sv),
        .sidx (sidx),
        .gone (gone)
    );

    // Drive issue slots from the chosen entries.
    always_comb begin
        iss_valid = sv;
        iss_seq   = '0;
        iss_cls   = '0;
        for (int s = 0; s < ISS_W; s++) begin
            if (sv[s]) begin
                iss_seq[s*SEQ_W +: SEQ_W] = ent[sidx[s]].seq;
                iss_cls[s*CLS_W +: CLS_W] = ent[sidx[s]].cls;
            end
        end
    end

    // Occupancy count and lowest free slot for allocation.
    always_comb begin
        occ       = '0;
        alloc_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            occ = occ + CNT_W'(ent[i].vld);
            if (!ent[i].vld) alloc_idx = IDX_W'(i);
        end
        free_cnt = CNT_W'(N_ENT) - occ;
        full     = (occ == CNT_W'(N_ENT));
    end

    // Entry state: issue removal, squash, wakeup, commit release, allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) ent[i] <= '0;
        end else begin
            for (int i = 0; i < N_ENT; i++) begin
                if (gone[i]) begin
                    ent[i].vld <= 1'b0;
                end else if (squash_valid && ent[i].vld && (ent[i].seq > squash_seq)) begin
                    ent[i].vld <= 1'b0;
                end else if (ent[i].vld) begin
                    if (wake_valid && (ent[i].s0 == wake_reg)) ent[i].r0 <= 1'b1;
                    if (wake_valid && (ent[i].s1 == wake_reg)) ent[i].r1 <= 1'b1;
                    if (commit_valid && ent[i].nonspec && (ent[i].seq == commit_seq))
                        ent[i].rel <= 1'b1;
                end
                if (disp_ok && (alloc_idx == IDX_W'(i))) begin
                    ent[i].vld     <= 1'b1;
                    ent[i].seq     <= disp_seq;
                    ent[i].cls     <= disp_cls;
                    ent[i].s0      <= disp_src0;
                    ent[i].s1      <= disp_src1;
                    ent[i].r0      <= sr0;
                    ent[i].r1      <= sr1;
                    ent[i].nonspec <= disp_nonspec;
                    ent[i].rel     <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/iq_top_chk.sv
`timescale 1ns/1ps
// Port-level property checker for the issue queue, bound to iq_top.
module iq_top_chk
    import iq_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    disp_valid,
    input logic                    squash_valid,
    input logic [SEQ_W-1:0]        squash_seq,
    input logic [CNT_W-1:0]        free_cnt,
    input logic                    full,
    input logic [ISS_W-1:0]        iss_valid,
    input logic [ISS_W*SEQ_W-1:0]  iss_seq
);
    // R2: free count never exceeds the capacity.
    a_r2_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= CNT_W'(N_ENT));

    // R2: with nothing leaving, a full queue stays full (dispatch dropped).
    a_r2_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (full && iss_valid == '0 && !squash_valid) |=> full);

    // R2: at most one entry is added per cycle.
    a_r2_free_step: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (int'(free_cnt) + 1 >= int'($past(free_cnt))));

    // R11: issued entries free their slots at the edge.
    a_r11_issue_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid != '0 && !disp_valid && !squash_valid) |=>
        (int'(free_cnt) == int'($past(free_cnt)) + $countones($past(iss_valid))));

    for (genvar s = 0; s < ISS_W; s++) begin : g_slot
        // R10: nothing younger than the squash number issues in the squash cycle.
        a_r10_squash_issue: assert property (@(posedge clk) disable iff (!rst_n)
            (squash_valid && iss_valid[s]) |-> (iss_seq[s*SEQ_W +: SEQ_W] <= squash_seq));
        if (s + 1 < ISS_W) begin : g_gap
            // R8: slots fill from slot 0 without gaps.
            a_r8_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
                iss_valid[s+1] |-> iss_valid[s]);
        end
    end
endmodule

bind iq_top iq_top_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .disp_valid   (disp_valid),
    .squash_valid (squash_valid),
    .squash_seq   (squash_seq),
    .free_cnt     (free_cnt),
    .full         (full),
    .iss_valid    (iss_valid),
    .iss_seq      (iss_seq)
);

// File: tb/iq_top_bench.sv
`timescale 1ns/1ps
// Directed bench with a cycle reference model of the queue.
module iq_top_bench;
    import iq_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic disp_valid = 0, disp_has_dst = 0, disp_nonspec = 0;
    logic [SEQ_W-1:0] disp_seq = '0, commit_seq = '0, squash_seq = '0;
    logic [CLS_W-1:0] disp_cls = '0;
    logic [PREG_W-1:0] disp_src0 = '0, disp_src1 = '0, disp_dst = '0, wake_reg = '0;
    logic wake_valid = 0, commit_valid = 0, squash_valid = 0;
    logic [CNT_W-1:0] free_cnt;
    logic full;
    logic [ISS_W-1:0] iss_valid;
    logic [ISS_W*SEQ_W-1:0] iss_seq;
    logic [ISS_W*CLS_W-1:0] iss_cls;

    iq_top u_iq_top (.*);

    int n_chk = 0, n_bad = 0, sq = 1;
    string req = "R1";
    bit seen [256];

    bit m_v[N_ENT], m_r0[N_ENT], m_r1[N_ENT], m_ns[N_ENT], m_rel[N_ENT];
    int m_seq[N_ENT], m_cls[N_ENT], m_s0[N_ENT], m_s1[N_ENT];
    bit m_sb[N_PREG];

    task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    function automatic int m_count();
        int n = 0;
        for (int i = 0; i < N_ENT; i++) n += m_v[i];
        return n;
    endfunction

    // One cycle: compare outputs against the model, then advance the model.
    task automatic step();
        int e_idx[ISS_W];
        bit e_v[ISS_W];
        bit tk[N_ENT];
        int slot, cnt;
        @(negedge clk);
        slot = 0;
        for (int s = 0; s < ISS_W; s++) begin e_v[s] = 0; e_idx[s] = 0; end
        for (int i = 0; i < N_ENT; i++) tk[i] = 0;
        for (int c = 0; c < N_CLS; c++) begin
            for (int k = 0; k < ((c == 0) ? 2 : 1); k++) begin
                int best = -1;
                for (int i = 0; i < N_ENT; i++) begin
                    if (m_v[i] && !tk[i] && m_r0[i] && m_r1[i] && m_cls[i] == c &&
                        (!m_ns[i] || m_rel[i]) &&
                        !(squash_valid && m_seq[i] > int'(squash_seq)) &&
                        (best < 0 || m_seq[i] < m_seq[best]))
                        best = i;
                end
                if (best >= 0 && slot < ISS_W) begin
                    tk[best] = 1; e_v[slot] = 1; e_idx[slot] = best; slot++;
                end
            end
        end
        for (int s = 0; s < ISS_W; s++) begin
            chk(iss_valid[s] == e_v[s], req, $sformatf("slot%0d valid", s), iss_valid[s], e_v[s]);
            if (e_v[s] && iss_valid[s]) begin
                chk(int'(iss_seq[s*SEQ_W +: SEQ_W]) == m_seq[e_idx[s]], req,
                    $sformatf("slot%0d seq", s), iss_seq[s*SEQ_W +: SEQ_W], m_seq[e_idx[s]]);
                chk(int'(iss_cls[s*CLS_W +: CLS_W]) == m_cls[e_idx[s]], req,
                    $sformatf("slot%0d cls", s), iss_cls[s*CLS_W +: CLS_W], m_cls[e_idx[s]]);
            end
            if (iss_valid[s]) seen[iss_seq[s*SEQ_W +: SEQ_W]] = 1;
        end
        cnt = m_count();
        chk(int'(free_cnt) == N_ENT - cnt, "R2", "free_cnt", free_cnt, N_ENT - cnt);
        chk(full == (cnt == N_ENT), "R2", "full", full, cnt == N_ENT);
        @(posedge clk);
        for (int s = 0; s < ISS_W; s++) if (e_v[s]) m_v[e_idx[s]] = 0;
        for (int i = 0; i < N_ENT; i++) begin
            if (squash_valid && m_v[i] && m_seq[i] > int'(squash_seq)) m_v[i] = 0;
            if (m_v[i] && wake_valid && m_s0[i] == int'(wake_reg)) m_r0[i] = 1;
            if (m_v[i] && wake_valid && m_s1[i] == int'(wake_reg)) m_r1[i] = 1;
            if (m_v[i] && commit_valid && m_ns[i] && m_seq[i] == int'(commit_seq)) m_rel[i] = 1;
        end
        if (disp_valid && !squash_valid && cnt < N_ENT) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (!m_v[i] && !(e_v[0] && e_idx[0] == i) && !(e_v[1] && e_idx[1] == i) &&
                    !(e_v[2] && e_idx[2] == i)) begin
                    m_v[i] = 1; m_seq[i] = disp_seq; m_cls[i] = disp_cls;
                    m_s0[i] = disp_src0; m_s1[i] = disp_src1;
                    m_r0[i] = m_sb[disp_src0] || (wake_valid && wake_reg == disp_src0);
                    m_r1[i] = m_sb[disp_src1] || (wake_valid && wake_reg == disp_src1);
                    m_ns[i] = disp_nonspec; m_rel[i] = 0;
                    break;
                end
            end
        end
        if (wake_valid) m_sb[wake_reg] = 1;
        if (disp_valid && !squash_valid && cnt < N_ENT && disp_has_dst) m_sb[disp_dst] = 0;
        #1;
        disp_valid = 0; wake_valid = 0; commit_valid = 0; squash_valid = 0;
        disp_has_dst = 0; disp_nonspec = 0;
    endtask

    // Present one dispatch; returns its sequence number.
    task automatic disp(input int cls, input int s0, input int s1, input bit hd,
                        input int dst, input bit ns, output int seq);
        seq = sq; sq++;
        disp_valid = 1; disp_seq = SEQ_W'(seq); disp_cls = CLS_W'(cls);
        disp_src0 = PREG_W'(s0); disp_src1 = PREG_W'(s1);
        disp_has_dst = hd; disp_dst = PREG_W'(dst); disp_nonspec = ns;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic wake(input int r);
        wake_valid = 1; wake_reg = PREG_W'(r);
    endtask

    task automatic t_reset();
        req = "R1";
        for (int i = 0; i < N_ENT; i++) m_v[i] = 0;
        for (int r = 0; r < N_PREG; r++) m_sb[r] = 1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(free_cnt == 16, "R1", "free_cnt after reset", free_cnt, 16);
        chk(full == 0, "R1", "full after reset", full, 0);
        chk(iss_valid == 0, "R1", "issue after reset", iss_valid, 0);
        @(posedge clk); #1;
        idle(1);
    endtask

    task automatic t_basic();
        int s;
        req = "R11";
        for (int k = 0; k < 3; k++) begin disp(C_INT, 0, 1, 0, 0, 0, s); step(); end
        idle(3);
    endtask

    task automatic t_wake();
        int s, c;
        req = "R3";
        disp(C_MISC, 0, 1, 1, 10, 0, s); step();
        disp(C_INT, 10, 1, 0, 0, 0, c); step();
        idle(3);
        chk(seen[c] == 0, "R3", "consumer issued before broadcast", seen[c], 0);
        req = "R4";
        wake(10); step();
        idle(2);
        chk(seen[c] == 1, "R4", "consumer issued after broadcast", seen[c], 1);
    endtask

    task automatic t_bypass();
        int s, c;
        req = "R5";
        disp(C_MISC, 0, 1, 1, 11, 0, s); step();
        idle(2);
        disp(C_BR, 1, 11, 0, 0, 0, c); wake(11); step();
        step();
        chk(seen[c] == 1, "R5", "bypassed consumer issues next cycle", seen[c], 1);
        idle(1);
    endtask

    task automatic t_oldest();
        int s, a, b, x, y, z;
        req = "R6";
        disp(C_MISC, 0, 1, 1, 12, 0, s); step();
        disp(C_MISC, 0, 1, 1, 13, 0, s); step();
        disp(C_FP, 12, 1, 0, 0, 0, a); step();
        disp(C_FP, 13, 0, 0, 0, 0, b); step();
        disp(C_FP, 12, 12, 0, 0, 0, x); step();
        disp(C_FP, 0, 0, 0, 0, 0, y); step();
        step();
        chk(seen[y] == 1 && seen[a] == 0, "R6", "young ready passes old waiting", seen[y], 1);
        wake(12); step();
        wake(13); step();
        disp(C_FP, 0, 0, 0, 0, 0, z); step();
        idle(4);
        chk(seen[x] == 1 && seen[b] == 1 && seen[z] == 1, "R6", "all FP drained", seen[z], 1);
    endtask

    task automatic t_cap();
        int s;
        req = "R8";
        disp(C_MISC, 0, 1, 1, 14, 0, s); step();
        idle(1);
        req = "R7";
        for (int k = 0; k < 3; k++) begin disp(C_INT, 14, 0, 0, 0, 0, s); step(); end
        for (int k = 0; k < 2; k++) begin disp(C_FP, 14, 0, 0, 0, 0, s); step(); end
        disp(C_BR, 14, 0, 0, 0, 0, s); step();
        disp(C_MEM, 0, 14, 0, 0, 0, s); step();
        disp(C_MISC, 14, 14, 0, 0, 0, s); step();
        req = "R8";
        wake(14); step();
        idle(5);
    endtask

    task automatic t_nonspec();
        int s;
        req = "R9";
        disp(C_INT, 0, 1, 0, 0, 1, s); step();
        idle(3);
        commit_valid = 1; commit_seq = SEQ_W'(s + 1); step();
        idle(2);
        chk(seen[s] == 0, "R9", "held entry issued early", seen[s], 0);
        commit_valid = 1; commit_seq = SEQ_W'(s); step();
        step();
        chk(seen[s] == 1, "R9", "released entry issued", seen[s], 1);
        idle(1);
    endtask

    task automatic t_squash();
        int s, a, b, c, n, r, d;
        req = "R10";
        disp(C_MISC, 0, 1, 1, 15, 0, s); step();
        idle(1);
        disp(C_INT, 15, 0, 0, 0, 0, a); step();
        disp(C_FP, 15, 0, 0, 0, 0, b); step();
        disp(C_BR, 15, 0, 0, 0, 0, c); step();
        disp(C_MEM, 0, 1, 0, 0, 1, n); step();
        disp(C_INT, 0, 1, 0, 0, 0, r); step();
        squash_valid = 1; squash_seq = SEQ_W'(b);
        disp(C_INT, 0, 1, 0, 0, 0, d); step();
        wake(15); step();
        commit_valid = 1; commit_seq = SEQ_W'(n); step();
        idle(3);
        chk(seen[a] == 1, "R10", "older entry survives squash", seen[a], 1);
        chk(seen[c] == 0, "R10", "younger waiting entry removed", seen[c], 0);
        chk(seen[n] == 0, "R10", "held entry removed", seen[n], 0);
        chk(seen[r] == 0, "R10", "ready younger entry suppressed", seen[r], 0);
        chk(seen[d] == 0, "R10", "dispatch in squash cycle dropped", seen[d], 0);
    endtask

    task automatic t_full();
        int s, d;
        req = "R2";
        disp(C_MISC, 0, 1, 1, 16, 0, s); step();
        idle(2);
        for (int k = 0; m_count() < N_ENT; k++) begin
            disp(k % N_CLS, 16, 0, 0, 0, 0, s); step();
        end
        @(negedge clk);
        chk(full == 1, "R2", "full at capacity", full, 1);
        chk(free_cnt == 0, "R2", "free_cnt at capacity", free_cnt, 0);
        @(posedge clk); #1;
        disp(C_INT, 0, 1, 0, 0, 0, d); step();
        idle(1);
        wake(16); step();
        idle(16);
        chk(seen[d] == 0, "R2", "dropped dispatch issued", seen[d], 0);
        chk(free_cnt == 16, "R2", "drained", free_cnt, 16);
    endtask

    bit done = 0;
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_wake();
        t_bypass();
        t_oldest();
        t_cap();
        t_nonspec();
        t_squash();
        t_full();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule